// File: doc/BRIEF.md
# Serial Game Controller Port

This block presents an eight-button game pad to a processor as a single-bit memory-mapped port. The processor arms the port by writing a 1 to the strobe bit and captures a snapshot of the buttons by writing a 0 afterwards. From then on, each read of the port returns one button on its data bit and advances the internal shift register. The sequence is fixed: A, B, Select, Start, Up, Down, Left, Right. Once all eight buttons have gone out, every further read returns 1 until the port is latched again.

While the strobe bit stays at 1, the snapshot is refreshed on every clock and reads do not advance. Each such read returns the live state of the A button. Address decoding lives outside the block. A system with two pads uses two instances, one for each decoded port address.

Top module: `pad_serial_port`

## Requirements
- R1: After reset the strobe is 0, `rd_bit` is 0, and the snapshot is all ones. Reads made before any latch therefore return 1.
- R2: While the strobe is 1, a read returns the value of `btn_in[0]` (A) at that read's clock edge. The shift register does not advance.
- R3: A write of 0 made while the strobe is 1 latches the `btn_in` value present at the clock edge of that write.
- R4: After a latch, successive reads return `btn_in[0]` through `btn_in[7]`, in this order: bit 0 A, bit 1 B, bit 2 Select, bit 3 Start, bit 4 Up, bit 5 Down, bit 6 Left, bit 7 Right. A 1 means the button is pressed.
- R5: Once eight buttons have been read after a latch, each further read returns 1 until the next latch.
- R6: Changes on `btn_in` after a latch have no effect on the values shifted out.
- R7: `rd_bit` is registered. It changes only at the clock edge that ends a cycle with `rd_en` high, and it holds its value otherwise.
- R8: When a read and a strobe write fall in the same cycle, the read acts on the strobe value from before the write.
- R9: A write of 0 while the strobe is already 0 does not reload the snapshot. The read sequence continues where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_in | input | 8 | Raw button levels, 1 = pressed, bit order as in R4 |
| wr_en | input | 1 | Processor write to the port this cycle |
| wr_bit | input | 1 | Data bit 0 of that write (strobe value) |
| rd_en | input | 1 | Processor read of the port this cycle |
| rd_bit | output | 1 | Serial button bit returned by the most recent read |

## Verification
A read and a strobe write can land in the same cycle. Two cases matter: a read issued alongside the 1-to-0 write that closes the latch, and a read issued alongside a write of 1 in the middle of a shift sequence. The bench provokes both by raising `rd_en` and `wr_en` at the same clock edge. It then judges the result from the returned bit and the bits read afterwards. In the first case, A must be returned twice and the sequence must not skip B. In the second case, the read must shift out the pending button, and the next read must follow the live A input.

// File: rtl/pad_pkg.sv
package pad_pkg;

  localparam int unsigned PAD_BTN_COUNT = 8;

  // Position of each button in the serial order (bit index of btn_in)
  typedef enum logic [2:0] {
    PAD_A      = 3'd0,
    PAD_B      = 3'd1,
    PAD_SELECT = 3'd2,
    PAD_START  = 3'd3,
    PAD_UP     = 3'd4,
    PAD_DOWN   = 3'd5,
    PAD_LEFT   = 3'd6,
    PAD_RIGHT  = 3'd7
  } pad_btn_e;

endpackage

// File: rtl/pad_strobe_reg.sv
module pad_strobe_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic strobe_q
);

  always_ff @(posedge clk) begin
    if (rst)
      strobe_q <= 1'b0;
    else if (wr_en)
      strobe_q <= wr_bit;
  end

endmodule

// File: rtl/pad_shifter.sv
module pad_shifter #(
  parameter int unsigned N_BTN    = 8,
  parameter logic        FILL_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_q,
  input  logic             shift_en,
  input  logic [N_BTN-1:0] btn_in,
  output logic             head
);

  localparam logic [N_BTN-1:0] EMPTY = {N_BTN{FILL_BIT}};

  logic [N_BTN-1:0] sr_q;

  // Strobe high: reload every clock. Strobe low: shift toward bit 0 on each read.
  always_ff @(posedge clk) begin
    if (rst)
      sr_q <= EMPTY;
    else if (strobe_q)
      sr_q <= btn_in;
    else if (shift_en)
      sr_q <= {FILL_BIT, sr_q[N_BTN-1:1]};
  end

  assign head = sr_q[0];

endmodule

// File: rtl/pad_readout.sv
module pad_readout (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic strobe_q,
  input  logic live_first,
  input  logic head,
  output logic rd_bit
);

  always_ff @(posedge clk) begin
    if (rst)
      rd_bit <= 1'b0;
    else if (rd_en)
      rd_bit <= strobe_q ? live_first : head;
  end

endmodule

// File: rtl/pad_serial_port.sv
module pad_serial_port #(
  parameter int unsigned N_BTN    = pad_pkg::PAD_BTN_COUNT,
  parameter logic        FILL_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] btn_in,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_en,
  output logic             rd_bit
);

  logic strobe_q;
  logic head;

  pad_strobe_reg u_strobe (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_bit   (wr_bit),
    .strobe_q (strobe_q)
  );

  pad_shifter #(.N_BTN(N_BTN), .FILL_BIT(FILL_BIT)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .strobe_q (strobe_q),
    .shift_en (rd_en),
    .btn_in   (btn_in),
    .head     (head)
  );

  pad_readout u_out (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .strobe_q   (strobe_q),
    .live_first (btn_in[0]),
    .head       (head),
    .rd_bit     (rd_bit)
  );

endmodule

// File: rtl/pad_serial_port_chk.sv
module pad_serial_port_chk #(
  parameter int unsigned N_BTN = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_BTN-1:0] btn_in,
  input logic             wr_en,
  input logic             wr_bit,
  input logic             rd_en,
  input logic             rd_bit,
  input logic             strobe_q
);

  localparam int unsigned CW = $clog2(N_BTN + 1);
  localparam int unsigned IW = (N_BTN > 1) ? $clog2(N_BTN) : 1;

  logic [N_BTN-1:0] snap_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '1;
      cnt_q  <= CW'(N_BTN);
    end else begin
      if (strobe_q && wr_en && !wr_bit)
        snap_q <= btn_in;
      if (strobe_q)
        cnt_q <= '0;
      else if (rd_en && cnt_q < CW'(N_BTN))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_bit));

  // R2 (also R8: the strobe value before the write decides)
  strobe_live_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && strobe_q) |=> (rd_bit == $past(btn_in[0])));

  // R5
  drained_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !strobe_q && cnt_q >= CW'(N_BTN)) |=> rd_bit);

  // R4
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !strobe_q && cnt_q < CW'(N_BTN)) |=> (rd_bit == $past(snap_q[cnt_q[IW-1:0]])));

endmodule

bind pad_serial_port pad_serial_port_chk #(.N_BTN(N_BTN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .btn_in   (btn_in),
  .wr_en    (wr_en),
  .wr_bit   (wr_bit),
  .rd_en    (rd_en),
  .rd_bit   (rd_bit),
  .strobe_q (strobe_q)
);

// File: tb/test_pad_serial_port.sv
module test_pad_serial_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] btn_in = 8'h00;
  logic       wr_en = 1'b0;
  logic       wr_bit = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_bit;

  int errors = 0;
  int checks = 0;
  logic r;

  always #4 clk = ~clk;

  pad_serial_port i_pad_serial_port (
    .clk(clk), .rst(rst), .btn_in(btn_in),
    .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en), .rd_bit(rd_bit)
  );

  // Patterns to latch; read k must return bit k (R4)
  localparam int NV = 5;
  localparam logic [7:0] PAT [NV] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle with the given controls, driven at negedge, sampled at next negedge
  task automatic cyc(input logic we, input logic wb, input logic re);
    @(negedge clk);
    wr_en = we; wr_bit = wb; rd_en = re;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_read(output logic v);
    cyc(1'b0, 1'b0, 1'b1);
    v = rd_bit;
  endtask

  task automatic latch(input logic [7:0] b);
    cyc(1'b1, 1'b1, 1'b0);
    btn_in = b;
    cyc(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_bit after reset", rd_bit, 1'b0);
    do_read(r); check("R1 read before latch", r, 1'b1);
    do_read(r); check("R1 second read before latch", r, 1'b1);

    // Vector table: R3, R4, R6, R5
    for (int v = 0; v < NV; v++) begin
      latch(PAT[v]);
      btn_in = ~PAT[v]; // R6: later changes must not matter
      for (int k = 0; k < 8; k++) begin
        do_read(r);
        check($sformatf("R4 pat %0d bit %0d", v, k), r, PAT[v][k]);
      end
      for (int k = 0; k < 2; k++) begin
        do_read(r);
        check("R5 read after eight", r, 1'b1);
      end
    end

    // R2: strobe held high follows live A, no advance
    cyc(1'b1, 1'b1, 1'b0);
    btn_in = 8'hFE; do_read(r); check("R2 live A low", r, 1'b0);
    btn_in = 8'h01; do_read(r); check("R2 live A high", r, 1'b1);
    btn_in = 8'h00; do_read(r); check("R2 live A low again", r, 1'b0);

    // R3: value at the edge of the 0 write is captured, not a later one
    @(negedge clk);
    btn_in = 8'h02; wr_en = 1'b1; wr_bit = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; btn_in = 8'hFD;
    do_read(r); check("R3 latched A", r, 1'b0);
    do_read(r); check("R3 latched B", r, 1'b1);

    // R7: rd_bit holds without reads while inputs move
    btn_in = 8'h00;
    cyc(1'b0, 1'b0, 1'b0);
    btn_in = 8'hFF;
    cyc(1'b0, 1'b0, 1'b0);
    check("R7 hold without read", rd_bit, 1'b1);

    // R8 case 1: read together with the closing 0 write
    cyc(1'b1, 1'b1, 1'b0);
    btn_in = 8'h02;
    cyc(1'b1, 1'b0, 1'b1);
    check("R8 read with closing write", rd_bit, 1'b0);
    btn_in = 8'hFF;
    do_read(r); check("R8 A again after combined cycle", r, 1'b0);
    do_read(r); check("R8 B follows", r, 1'b1);
    do_read(r); check("R8 Select follows", r, 1'b0);

    // R8 case 2: read together with a write of 1 mid-sequence
    latch(8'h01);
    cyc(1'b1, 1'b1, 1'b1);
    check("R8 read shifts with arming write", rd_bit, 1'b1);
    btn_in = 8'h00;
    do_read(r); check("R8 next read follows live A", r, 1'b0);

    // R9: extra 0 write does not reload
    latch(8'h04);
    do_read(r); check("R9 bit0", r, 1'b0);
    do_read(r); check("R9 bit1", r, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    btn_in = 8'h00;
    do_read(r); check("R9 continues at bit2", r, 1'b1);

    // R1 reset mid-sequence restores the empty state
    latch(8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rd_bit after second reset", rd_bit, 1'b0);
    do_read(r); check("R1 read after second reset", r, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule